// File: doc/BRIEF.md
# Age-Ordered Issue Selector

This block picks instructions for execution out of two ready pools, one for integer work and one for floating-point work. Each instruction comes in through a single insert port. It carries an age tag, where a smaller tag means an older instruction. It also carries an operation class and an upper/lower sub-cluster bit that an earlier stage has already fixed. Bit 1 of the class steers the entry into the floating-point pool or the integer pool.

Every cycle, each pool looks at only its few oldest entries. Each of those entries is matched against the functional unit its class and sub-cluster demand. Every entry whose unit is idle and not already claimed by an older entry is granted. Each grant carries a completion delay, which is the register-read latency plus the execution latency of the class. The same grant comes back out exactly two cycles later as a release notice, so the issue-queue slot upstream can be recycled.

A flush port removes every entry younger than a given age tag. Upstream must keep ages unique while they are present and must never insert into a full pool.

Top module: `issue_select`

## Requirements
- R1: Within one cycle's grants, lane k holds the k-th oldest of the considered entries, where a smaller age tag is older. Granted ages rise with the lane index. Upstream keeps ages unique within a pool and never inserts into a full pool.
- R2: Each cycle only the INT_LANES oldest integer entries and the FP_LANES oldest floating-point entries are considered. Younger entries wait for a later cycle.
- R3: A considered entry is granted only if its unit's busy bit is low. Each unit accepts at most one grant per cycle, and the oldest claimant takes it.
- R4: The integer unit index is {upper bit, class bit 0}: 0 = lower ALU, 1 = lower multiplier, 2 = upper ALU, 3 = upper multiplier. The floating-point unit index is class bit 0 (0 = add, 1 = multiply), and the sub-cluster bit is ignored for floating-point work.
- R5: The granted delay equals REG_LAT plus the class latency. Classes are encoded ALU=0, MUL=1, FADD=2, FMUL=3. With the defaults the delays are 2, 8, 5 and 5.
- R6: A release notice with the same lane and age appears exactly two cycles after the grant, and never earlier.
- R7: An older considered entry whose unit is busy does not stop a younger considered entry from being granted a different unit in the same cycle.
- R8: When flush is asserted, every entry with an age greater than the flush age is dropped at that edge. None of them is granted, and an insert arriving in the same cycle with a greater age is discarded.
- R9: Grants are registered. An entry inserted at one edge can be granted at the following edge at the earliest. Reset empties both pools and clears all grant and release outputs.
- R10: Classes with bit 1 set enter only the floating-point pool, and the other classes enter only the integer pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_vld | input | 1 | Insert request |
| ins_age | input | AGE_W | Age tag of the inserted entry |
| ins_cls | input | 2 | Operation class |
| ins_upper | input | 1 | Sub-cluster assignment (1 = upper) |
| int_busy | input | 4 | Integer unit busy bits |
| fp_busy | input | 2 | Floating-point unit busy bits |
| flush_vld | input | 1 | Flush request |
| flush_age | input | AGE_W | Entries younger than this tag are dropped |
| int_iss_vld | output | INT_LANES | Integer grant per lane |
| int_iss_age | output | INT_LANES x AGE_W | Granted age per lane |
| int_iss_unit | output | INT_LANES x 2 | Granted integer unit per lane |
| int_iss_dly | output | INT_LANES x DLY_W | Completion delay per lane |
| fp_iss_vld | output | FP_LANES | Floating-point grant per lane |
| fp_iss_age | output | FP_LANES x AGE_W | Granted age per lane |
| fp_iss_unit | output | FP_LANES x 1 | Granted floating-point unit per lane |
| fp_iss_dly | output | FP_LANES x DLY_W | Completion delay per lane |
| int_rel_vld | output | INT_LANES | Integer release notice per lane |
| int_rel_age | output | INT_LANES x AGE_W | Released age per lane |
| fp_rel_vld | output | FP_LANES | Floating-point release notice per lane |
| fp_rel_age | output | FP_LANES x AGE_W | Released age per lane |

## Verification
A lost valid bit or a stale age in a pool shows at the grant lanes within one cycle. It appears as a missing grant, a duplicated grant, or ages out of order across the lanes once the affected entry ranks among the considered ones. A wrong rank count shifts grants into the wrong lane, or lets a fifth entry slip in ahead of time. The cycle-by-cycle model catches this on the first edge where the state differs. Faults in the release pipe appear exactly two cycles after the grant they belong to.

// File: rtl/isel_pkg.sv
package isel_pkg;

    localparam int INT_UNITS = 4;
    localparam int FP_UNITS  = 2;

    typedef enum logic [1:0] {
        OP_ALU  = 2'd0,
        OP_MUL  = 2'd1,
        OP_FADD = 2'd2,
        OP_FMUL = 2'd3
    } op_cls_e;

    function automatic logic cls_is_fp(op_cls_e c);
        return c[1];
    endfunction

    function automatic logic [1:0] int_unit_of(op_cls_e c, logic upper);
        return {upper, c[0]};
    endfunction

endpackage

// File: rtl/isel_pool.sv
module isel_pool #(
    parameter int DEPTH = 8,
    parameter int LANES = 4,
    parameter int UNITS = 4,
    parameter int AGE_W = 8,
    parameter int UW    = 2,
    parameter int DW    = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ins_vld,
    input  logic [AGE_W-1:0]            ins_age,
    input  logic [UW-1:0]               ins_unit,
    input  logic [DW-1:0]               ins_dly,
    input  logic [UNITS-1:0]            unit_busy,
    input  logic                        flush_vld,
    input  logic [AGE_W-1:0]            flush_age,
    output logic [LANES-1:0]            iss_vld,
    output logic [LANES-1:0][AGE_W-1:0] iss_age,
    output logic [LANES-1:0][UW-1:0]    iss_unit,
    output logic [LANES-1:0][DW-1:0]    iss_dly
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] valid;
    logic [AGE_W-1:0] age_q  [DEPTH];
    logic [UW-1:0]    unit_q [DEPTH];
    logic [DW-1:0]    dly_q  [DEPTH];

    logic [CW-1:0]    rank [DEPTH];
    logic [DEPTH-1:0] kill, cons, win, ins_hot;
    logic             have_free, ins_ok, dup;

    logic [LANES-1:0]            ln_vld;
    logic [LANES-1:0][AGE_W-1:0] ln_age;
    logic [LANES-1:0][UW-1:0]    ln_unit;
    logic [LANES-1:0][DW-1:0]    ln_dly;

    // age rank, flush kill and consideration window
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            kill[i] = valid[i] && flush_vld && (age_q[i] > flush_age);
            rank[i] = '0;
            for (int j = 0; j < DEPTH; j++) begin
                if (valid[j] && (age_q[j] < age_q[i]))
                    rank[i] = rank[i] + CW'(1);
            end
            cons[i] = valid[i] && !kill[i] && (rank[i] < CW'(LANES));
        end
    end

    // unit matching: the oldest considered claimant of an idle unit wins
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            win[i] = cons[i] && !unit_busy[unit_q[i]];
            for (int j = 0; j < DEPTH; j++) begin
                if (cons[j] && (age_q[j] < age_q[i]) && (unit_q[j] == unit_q[i]))
                    win[i] = 1'b0;
            end
        end
    end

    // lane k carries the winner of rank k
    always_comb begin
        ln_vld  = '0;
        ln_age  = '0;
        ln_unit = '0;
        ln_dly  = '0;
        for (int k = 0; k < LANES; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (win[i] && (rank[i] == CW'(k))) begin
                    ln_vld[k]  = 1'b1;
                    ln_age[k]  = age_q[i];
                    ln_unit[k] = unit_q[i];
                    ln_dly[k]  = dly_q[i];
                end
            end
        end
    end

    // first free slot for an insert
    always_comb begin
        ins_hot   = '0;
        have_free = 1'b0;
        dup       = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!valid[i] && !have_free) begin
                ins_hot[i] = 1'b1;
                have_free  = 1'b1;
            end
            if (valid[i] && (age_q[i] == ins_age))
                dup = 1'b1;
        end
        ins_ok = ins_vld && have_free && !(flush_vld && (ins_age > flush_age));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid    <= '0;
            iss_vld  <= '0;
            iss_age  <= '0;
            iss_unit <= '0;
            iss_dly  <= '0;
        end else begin
            valid <= (valid & ~win & ~kill) | (ins_ok ? ins_hot : '0);
            for (int i = 0; i < DEPTH; i++) begin
                if (ins_ok && ins_hot[i]) begin
                    age_q[i]  <= ins_age;
                    unit_q[i] <= ins_unit;
                    dly_q[i]  <= ins_dly;
                end
            end
            iss_vld  <= ln_vld;
            iss_age  <= ln_age;
            iss_unit <= ln_unit;
            iss_dly  <= ln_dly;
        end
    end

    AST_UNIQUE_AGE: assert property (@(posedge clk) disable iff (rst)
        ins_vld |-> !dup);                                                     // R1
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        ins_vld |-> have_free);                                                // R1

    for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
        AST_GRANT_UNIT_FREE: assert property (@(posedge clk) disable iff (rst)
            iss_vld[k] |-> (($past(unit_busy) & (UNITS'(1) << iss_unit[k])) == '0));   // R3
        AST_NO_FLUSHED_GRANT: assert property (@(posedge clk) disable iff (rst)
            iss_vld[k] |-> !($past(flush_vld) && (iss_age[k] > $past(flush_age))));  // R8
        if (k + 1 < LANES) begin : g_ord
            AST_LANE_ORDER: assert property (@(posedge clk) disable iff (rst)
                (iss_vld[k] && iss_vld[k+1]) |-> (iss_age[k] < iss_age[k+1]));      // R1
        end
    end

    for (genvar u = 0; u < UNITS; u++) begin : g_unit_chk
        logic [LANES-1:0] hit;
        always_comb begin
            for (int k = 0; k < LANES; k++)
                hit[k] = iss_vld[k] && (iss_unit[k] == UW'(u));
        end
        AST_ONE_PER_UNIT: assert property (@(posedge clk) disable iff (rst)
            $onehot0(hit));                                                    // R3
    end

endmodule

// File: rtl/isel_release.sv
module isel_release #(
    parameter int LANES  = 4,
    parameter int AGE_W  = 8,
    parameter int STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [LANES-1:0]            in_vld,
    input  logic [LANES-1:0][AGE_W-1:0] in_age,
    output logic [LANES-1:0]            out_vld,
    output logic [LANES-1:0][AGE_W-1:0] out_age
);
    logic [STAGES-1:0][LANES-1:0]            vld_sr;
    logic [STAGES-1:0][LANES-1:0][AGE_W-1:0] age_sr;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_sr[s] <= '0;
                age_sr[s] <= '0;
            end else if (s == 0) begin
                vld_sr[s] <= in_vld;
                age_sr[s] <= in_age;
            end else begin
                vld_sr[s] <= vld_sr[(s == 0) ? 0 : s-1];
                age_sr[s] <= age_sr[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign out_vld = vld_sr[STAGES-1];
    assign out_age = age_sr[STAGES-1];

endmodule

// File: rtl/issue_select.sv
module issue_select
    import isel_pkg::*;
#(
    parameter int INT_DEPTH = 8,
    parameter int FP_DEPTH  = 4,
    parameter int INT_LANES = 4,
    parameter int FP_LANES  = 2,
    parameter int AGE_W     = 8,
    parameter int DLY_W     = 4,
    parameter int REG_LAT   = 1,
    parameter int LAT_ALU   = 1,
    parameter int LAT_MUL   = 7,
    parameter int LAT_FADD  = 4,
    parameter int LAT_FMUL  = 4
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic                                           ins_vld,
    input  logic [AGE_W-1:0]                               ins_age,
    input  logic [1:0]                                     ins_cls,
    input  logic                                           ins_upper,
    input  logic [INT_UNITS-1:0]                           int_busy,
    input  logic [FP_UNITS-1:0]                            fp_busy,
    input  logic                                           flush_vld,
    input  logic [AGE_W-1:0]                               flush_age,
    output logic [INT_LANES-1:0]                           int_iss_vld,
    output logic [INT_LANES-1:0][AGE_W-1:0]                int_iss_age,
    output logic [INT_LANES-1:0][$clog2(INT_UNITS)-1:0]    int_iss_unit,
    output logic [INT_LANES-1:0][DLY_W-1:0]                int_iss_dly,
    output logic [FP_LANES-1:0]                            fp_iss_vld,
    output logic [FP_LANES-1:0][AGE_W-1:0]                 fp_iss_age,
    output logic [FP_LANES-1:0][$clog2(FP_UNITS)-1:0]      fp_iss_unit,
    output logic [FP_LANES-1:0][DLY_W-1:0]                 fp_iss_dly,
    output logic [INT_LANES-1:0]                           int_rel_vld,
    output logic [INT_LANES-1:0][AGE_W-1:0]                int_rel_age,
    output logic [FP_LANES-1:0]                            fp_rel_vld,
    output logic [FP_LANES-1:0][AGE_W-1:0]                 fp_rel_age
);
    localparam int IUW = $clog2(INT_UNITS);
    localparam int FUW = $clog2(FP_UNITS);
    localparam logic [DLY_W-1:0] D_ALU  = DLY_W'(REG_LAT + LAT_ALU);
    localparam logic [DLY_W-1:0] D_MUL  = DLY_W'(REG_LAT + LAT_MUL);
    localparam logic [DLY_W-1:0] D_FADD = DLY_W'(REG_LAT + LAT_FADD);
    localparam logic [DLY_W-1:0] D_FMUL = DLY_W'(REG_LAT + LAT_FMUL);

    op_cls_e          cls;
    logic [DLY_W-1:0] ins_dly;
    logic             int_ins, fp_ins;
    logic [IUW-1:0]   int_unit;
    logic [FUW-1:0]   fp_unit;

    assign cls      = op_cls_e'(ins_cls);
    assign int_ins  = ins_vld && !cls_is_fp(cls);
    assign fp_ins   = ins_vld && cls_is_fp(cls);
    assign int_unit = int_unit_of(cls, ins_upper);
    assign fp_unit  = FUW'(ins_cls[0]);

    always_comb begin
        case (cls)
            OP_ALU:  ins_dly = D_ALU;
            OP_MUL:  ins_dly = D_MUL;
            OP_FADD: ins_dly = D_FADD;
            default: ins_dly = D_FMUL;
        endcase
    end

    isel_pool #(
        .DEPTH(INT_DEPTH), .LANES(INT_LANES), .UNITS(INT_UNITS),
        .AGE_W(AGE_W), .UW(IUW), .DW(DLY_W)
    ) u_int_pool (
        .clk(clk), .rst(rst),
        .ins_vld(int_ins), .ins_age(ins_age), .ins_unit(int_unit), .ins_dly(ins_dly),
        .unit_busy(int_busy), .flush_vld(flush_vld), .flush_age(flush_age),
        .iss_vld(int_iss_vld), .iss_age(int_iss_age), .iss_unit(int_iss_unit),
        .iss_dly(int_iss_dly)
    );

    isel_pool #(
        .DEPTH(FP_DEPTH), .LANES(FP_LANES), .UNITS(FP_UNITS),
        .AGE_W(AGE_W), .UW(FUW), .DW(DLY_W)
    ) u_fp_pool (
        .clk(clk), .rst(rst),
        .ins_vld(fp_ins), .ins_age(ins_age), .ins_unit(fp_unit), .ins_dly(ins_dly),
        .unit_busy(fp_busy), .flush_vld(flush_vld), .flush_age(flush_age),
        .iss_vld(fp_iss_vld), .iss_age(fp_iss_age), .iss_unit(fp_iss_unit),
        .iss_dly(fp_iss_dly)
    );

    isel_release #(.LANES(INT_LANES), .AGE_W(AGE_W), .STAGES(2)) u_int_rel (
        .clk(clk), .rst(rst), .in_vld(int_iss_vld), .in_age(int_iss_age),
        .out_vld(int_rel_vld), .out_age(int_rel_age)
    );

    isel_release #(.LANES(FP_LANES), .AGE_W(AGE_W), .STAGES(2)) u_fp_rel (
        .clk(clk), .rst(rst), .in_vld(fp_iss_vld), .in_age(fp_iss_age),
        .out_vld(fp_rel_vld), .out_age(fp_rel_age)
    );

    AST_INT_REL_TWO: assert property (@(posedge clk) disable iff (rst)
        int_rel_vld == $past(int_iss_vld, 2));                                 // R6
    AST_FP_REL_TWO: assert property (@(posedge clk) disable iff (rst)
        fp_rel_vld == $past(fp_iss_vld, 2));                                   // R6

endmodule

// File: tb/issue_select_test.sv
`timescale 1ns/1ps
module issue_select_test;
    localparam int ID = 8, FD = 4, IL = 4, FL = 2, AW = 8, DW = 4;

    logic clk = 1'b0, rst = 1'b1;
    logic ins_vld = 0, ins_upper = 0, flush_vld = 0;
    logic [AW-1:0] ins_age = 0, flush_age = 0;
    logic [1:0] ins_cls = 0, fp_busy = 0;
    logic [3:0] int_busy = 0;
    logic [IL-1:0] int_iss_vld, int_rel_vld;
    logic [IL-1:0][AW-1:0] int_iss_age, int_rel_age;
    logic [IL-1:0][1:0] int_iss_unit;
    logic [IL-1:0][DW-1:0] int_iss_dly;
    logic [FL-1:0] fp_iss_vld, fp_rel_vld;
    logic [FL-1:0][AW-1:0] fp_iss_age, fp_rel_age;
    logic [FL-1:0][0:0] fp_iss_unit;
    logic [FL-1:0][DW-1:0] fp_iss_dly;

    issue_select #(.INT_DEPTH(ID), .FP_DEPTH(FD), .INT_LANES(IL), .FP_LANES(FL),
                   .AGE_W(AW), .DLY_W(DW)) uut (.*);

    always #2.5 clk = ~clk;

    typedef struct { int age; int unit; int dly; } ent_t;
    ent_t iq[$], fq[$];
    bit [3:0] e_vld[2], p_vld[2], r_vld[2];
    int e_age[2][4], e_unit[2][4], e_dly[2][4], p_age[2][4], r_age[2][4];
    int n_chk = 0, n_err = 0, ctr = 1;

    task automatic check(input bit ok, input string what, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d at %0t", what, got, exp, $time);
        end
    endtask

    function automatic int cls_dly(input int c);
        case (c)
            0: return 2;
            1: return 8;
            default: return 5;
        endcase
    endfunction

    task automatic model_step();
        for (int pl = 0; pl < 2; pl++) begin
            ent_t q[$], keep[$];
            ent_t e;
            int depth, lanes, pre, pos;
            bit [3:0] busy, taken, winl;
            q = (pl == 1) ? fq : iq;
            depth = (pl == 1) ? FD : ID;
            lanes = (pl == 1) ? FL : IL;
            busy  = (pl == 1) ? {2'b00, fp_busy} : int_busy;
            pre = q.size();
            r_vld[pl] = p_vld[pl]; r_age[pl] = p_age[pl];
            p_vld[pl] = e_vld[pl]; p_age[pl] = e_age[pl];
            keep = {};
            foreach (q[i]) if (!(flush_vld && q[i].age > int'(flush_age))) keep.push_back(q[i]);
            q = keep;
            taken = 0; winl = 0; e_vld[pl] = 0;
            for (int k = 0; k < 4; k++) begin e_age[pl][k] = 0; e_unit[pl][k] = 0; e_dly[pl][k] = 0; end
            for (int k = 0; k < lanes && k < q.size(); k++) begin
                if (!busy[q[k].unit] && !taken[q[k].unit]) begin
                    taken[q[k].unit] = 1; winl[k] = 1; e_vld[pl][k] = 1;
                    e_age[pl][k] = q[k].age; e_unit[pl][k] = q[k].unit; e_dly[pl][k] = q[k].dly;
                end
            end
            keep = {};
            foreach (q[i]) if (!(i < 4 && winl[i])) keep.push_back(q[i]);
            q = keep;
            if (ins_vld && ins_cls[1] == pl[0] && pre < depth &&
                !(flush_vld && ins_age > flush_age)) begin
                e.age = ins_age;
                e.unit = (pl == 1) ? int'(ins_cls[0]) : int'({ins_upper, ins_cls[0]});
                e.dly = cls_dly(ins_cls);
                pos = q.size();
                for (int j = 0; j < q.size(); j++) if (q[j].age > e.age) begin pos = j; break; end
                q.insert(pos, e);
            end
            if (pl == 1) fq = q; else iq = q;
        end
    endtask

    task automatic compare();
        for (int pl = 0; pl < 2; pl++) begin
            for (int k = 0; k < ((pl == 1) ? FL : IL); k++) begin
                bit gv, rv; int ga, gu, gd, ra;
                if (pl == 0) begin
                    gv = int_iss_vld[k]; ga = int_iss_age[k]; gu = int_iss_unit[k];
                    gd = int_iss_dly[k]; rv = int_rel_vld[k]; ra = int_rel_age[k];
                end else begin
                    gv = fp_iss_vld[k]; ga = fp_iss_age[k]; gu = fp_iss_unit[k];
                    gd = fp_iss_dly[k]; rv = fp_rel_vld[k]; ra = fp_rel_age[k];
                end
                check(gv == e_vld[pl][k], "R2 R3 grant valid", gv, e_vld[pl][k]);
                if (gv && e_vld[pl][k]) begin
                    check(ga == e_age[pl][k], "R1 lane age", ga, e_age[pl][k]);
                    check(gu == e_unit[pl][k], "R4 unit", gu, e_unit[pl][k]);
                    check(gd == e_dly[pl][k], "R5 delay", gd, e_dly[pl][k]);
                end
                check(rv == r_vld[pl][k], "R6 release valid", rv, r_vld[pl][k]);
                if (rv && r_vld[pl][k]) check(ra == r_age[pl][k], "R6 release age", ra, r_age[pl][k]);
            end
        end
    endtask

    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        ins_vld = 0; flush_vld = 0; int_busy = 0; fp_busy = 0;
    endtask

    task automatic put(input int age, input int cls, input bit up);
        ins_vld = 1; ins_age = AW'(age); ins_cls = 2'(cls); ins_upper = up;
        cycle();
        ins_vld = 0;
    endtask

    task automatic clear();
        idle(); flush_vld = 1; flush_age = 0; int_busy = '1; fp_busy = '1;
        cycle();
        flush_vld = 0;
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        report();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R9: reset state
        check(int_iss_vld == 0 && fp_iss_vld == 0, "R9 reset grants", int'(int_iss_vld), 0);
        check(int_rel_vld == 0 && fp_rel_vld == 0, "R9 reset releases", int'(int_rel_vld), 0);
        rst = 0;

        // randomized phase, compared every cycle
        for (int n = 0; n < 4000; n++) begin
            int fa, c;
            idle();
            if (ctr >= 240) begin
                flush_vld = 1; flush_age = 0; ctr = 1;
            end else begin
                if ($urandom_range(99) < 4) begin
                    fa = ctr - 1 - int'($urandom_range(4));
                    flush_vld = 1; flush_age = AW'((fa < 0) ? 0 : fa);
                end
                c = $urandom_range(3);
                if ($urandom_range(99) < 70 &&
                    ((c >= 2) ? (fq.size() < FD) : (iq.size() < ID))) begin
                    ins_vld = 1; ins_age = AW'(ctr); ins_cls = 2'(c);
                    ins_upper = 1'($urandom_range(1)); ctr++;
                end
            end
            for (int b = 0; b < 4; b++) int_busy[b] = ($urandom_range(99) < 30);
            for (int b = 0; b < 2; b++) fp_busy[b] = ($urandom_range(99) < 30);
            cycle();
        end

        // R9 and R10: registered grant, class routing
        clear(); idle();
        put(10, 2, 1);
        check(fp_iss_vld == 0, "R9 no grant at insert edge", int'(fp_iss_vld), 0);
        cycle();
        check(fp_iss_vld == 2'b01 && fp_iss_age[0] == 10, "R9 grant next edge", int'(fp_iss_age[0]), 10);
        check(int_iss_vld == 0, "R10 fp class not on integer lanes", int'(int_iss_vld), 0);
        check(fp_iss_dly[0] == 5, "R5 fadd delay", int'(fp_iss_dly[0]), 5);

        // R7, R4, R5, R6: blocked older does not stop younger
        clear(); int_busy = '1;
        put(20, 0, 0);
        put(21, 1, 1);
        int_busy = 4'b0001;
        cycle();
        check(int_iss_vld == 4'b0010, "R7 younger issues past blocked older", int'(int_iss_vld), 2);
        check(int_iss_unit[1] == 3, "R4 upper multiplier unit", int'(int_iss_unit[1]), 3);
        check(int_iss_dly[1] == 8, "R5 mul delay", int'(int_iss_dly[1]), 8);
        int_busy = '1;
        cycle();
        check(int_rel_vld == 0, "R6 no early release", int'(int_rel_vld), 0);
        cycle();
        check(int_rel_vld == 4'b0010 && int_rel_age[1] == 21, "R6 release after two", int'(int_rel_age[1]), 21);

        // R2 and R1: window of four oldest
        clear(); int_busy = '1;
        put(30, 0, 0); put(31, 1, 0); put(32, 0, 1); put(33, 1, 1); put(34, 0, 0);
        int_busy = 0;
        cycle();
        check(int_iss_vld == 4'b1111, "R2 four oldest granted", int'(int_iss_vld), 15);
        check(int_iss_age[0] == 30 && int_iss_age[3] == 33, "R1 lane order", int'(int_iss_age[3]), 33);
        cycle();
        check(int_iss_vld == 4'b0001 && int_iss_age[0] == 34, "R2 fifth waits", int'(int_iss_age[0]), 34);

        // R3: shared unit, oldest first
        clear(); int_busy = '1;
        put(40, 0, 1); put(41, 0, 1);
        int_busy = 0;
        cycle();
        check(int_iss_vld == 4'b0001 && int_iss_age[0] == 40, "R3 oldest takes unit", int'(int_iss_age[0]), 40);
        cycle();
        check(int_iss_vld == 4'b0001 && int_iss_age[0] == 41, "R3 younger next cycle", int'(int_iss_age[0]), 41);

        // R8: flush drops younger entries and a younger insert
        clear(); int_busy = '1;
        put(50, 0, 0); put(51, 0, 1); put(52, 1, 1);
        int_busy = 0; flush_vld = 1; flush_age = 50;
        ins_vld = 1; ins_age = 53; ins_cls = 1; ins_upper = 0;
        cycle();
        idle();
        check(int_iss_vld == 4'b0001 && int_iss_age[0] == 50, "R8 only older granted", int'(int_iss_vld), 1);
        cycle();
        check(int_iss_vld == 0, "R8 flushed entries gone", int'(int_iss_vld), 0);

        report();
    end
endmodule